// File: doc/BRIEF.md
# DMA Bus Hold Handover Controller

This block sits on the processor side of a shared system bus. It decides when the processor lets go of its address, data and control drivers so that an external DMA master can use the bus, and when the processor takes them back. A hold request is accepted only at the end of a machine cycle. The block then turns off every bus driver enable and, one clock later, raises a hold acknowledge to the requester. The processor core's own bus requests are stalled for the whole period in which the bus is not its own.

While the acknowledge is high, the block watches write strobes from the DMA master. Each written address is compared against a small set of cache tags that the cache supplies. A match produces a per-way command one clock later. A mode input selects the command: either an invalidate, or an update that carries the written byte. When the hold request drops, the acknowledge falls first. The drivers come back one clock after that, and the processor carries on from the point where it stopped.

Top module: `bus_hold_ctrl`

## Requirements
- R1: The bus driver enable `bus_oe` falls only after a clock edge at which `hold_req` and `cycle_end` are both 1. A hold request with `cycle_end` low keeps `bus_oe` at 1, and the controller waits until a later edge sees `cycle_end` at 1.
- R2: The controller holds `bus_oe` at 0 (address, data and control drivers floated) from the edge where the hold is taken until the release cycle ends.
- R3: `hold_ack` rises one clock after `bus_oe` falls. It stays at 1 while `hold_req` remains 1, and it is never at 1 while `bus_oe` is 1.
- R4: When `hold_req` is 0 at an edge during the hold, `hold_ack` falls at that edge. `bus_oe` returns to 1 one clock later.
- R5: If `hold_req` drops before any edge sees `cycle_end` at 1, the request is abandoned. `bus_oe` stays 1 and `hold_ack` never rises.
- R6: `core_stall` is 1 exactly when `bus_oe` is 0, so it is 1 whenever `hold_ack` is 1.
- R7: A snoop compare happens only at an edge where both `dma_wr` and `hold_ack` are 1. Its results appear one clock later and last one clock. In every other cycle, `snoop_way`, `snoop_inv` and `snoop_upd` are 0.
- R8: For a snoop compare, bit i of `snoop_way` is 1 when `tag_valid[i]` is 1 and tag i, held at `tag_addr[i*AW +: AW]`, equals `dma_addr`. More than one bit may be set.
- R9: A compare with at least one matching way pulses `snoop_inv` when `snoop_mode` is 0, or `snoop_upd` when `snoop_mode` is 1. `snoop_data` then carries the `dma_wdata` of that write. A compare with no match pulses neither.
- R10: After reset, `bus_oe` is 1, and `hold_ack`, `core_stall`, `snoop_way`, `snoop_inv`, `snoop_upd` and `snoop_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_req | input | 1 | Bus hold request from the DMA master |
| cycle_end | input | 1 | The current processor machine cycle finishes at this edge |
| dma_wr | input | 1 | DMA master write strobe |
| dma_addr | input | AW | DMA write address |
| dma_wdata | input | DW | DMA write data |
| snoop_mode | input | 1 | 0 = invalidate matching ways, 1 = update them |
| tag_addr | input | NTAG*AW | Cached addresses, tag i in bits i*AW +: AW |
| tag_valid | input | NTAG | Valid bit per tag |
| bus_oe | output | 1 | Enable for the address, data and control drivers (0 = floated) |
| hold_ack | output | 1 | Hold acknowledge to the DMA master |
| core_stall | output | 1 | Stalls the processor core's internal bus requests |
| snoop_way | output | NTAG | Ways that matched the last snooped write |
| snoop_inv | output | 1 | Invalidate command pulse |
| snoop_upd | output | 1 | Update command pulse |
| snoop_data | output | DW | Data for the update command |

## Verification
`bus_oe` and `core_stall` change at the same edge that samples the hold or release condition. `hold_ack` follows one clock after `bus_oe` falls, and it falls one clock before `bus_oe` returns. The snoop outputs appear one clock after the edge that sampled the DMA write. The bench drives its inputs on the falling clock edge and updates a behavioural model at each rising edge. It compares every output with that model at the next falling edge, so each result is checked in the exact cycle it is due. The stimulus includes cycle-end waits of several lengths, an abandoned request, and a re-request during release. It also includes writes in the first held cycle, before the acknowledge is up, as well as writes outside the hold, misses, an invalid tag, a match on two ways and both snoop modes.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_HELD = 2'd2,
        ST_REL  = 2'd3
    } hold_state_e;

    typedef struct packed {
        hold_state_e state;
        logic        ack;
    } fsm_regs_t;

endpackage

// File: rtl/bhc_hold_fsm.sv
module bhc_hold_fsm
    import bhc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic cycle_end,
    output logic bus_oe,
    output logic hold_ack,
    output logic core_stall
);

    fsm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        case (regs_q.state)
            ST_RUN: begin
                if (hold_req) begin
                    regs_d.state = cycle_end ? ST_HELD : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!hold_req) begin
                    regs_d.state = ST_RUN;
                end else if (cycle_end) begin
                    regs_d.state = ST_HELD;
                end
            end
            ST_HELD: begin
                if (!hold_req) begin
                    regs_d.state = ST_REL;
                end
            end
            default: begin
                regs_d.state = ST_RUN;
            end
        endcase
        // acknowledge only once the drivers have been off for a full cycle
        regs_d.ack = (regs_q.state == ST_HELD) && (regs_d.state == ST_HELD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{state: ST_RUN, ack: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_oe     = (regs_q.state == ST_RUN) || (regs_q.state == ST_WAIT);
    assign core_stall = (regs_q.state == ST_HELD) || (regs_q.state == ST_REL);
    assign hold_ack   = regs_q.ack;

endmodule

// File: rtl/bhc_tag_match.sv
module bhc_tag_match #(
    parameter int AW   = 16,
    parameter int NTAG = 4
) (
    input  logic [AW-1:0]      addr,
    input  logic [NTAG*AW-1:0] tag_addr,
    input  logic [NTAG-1:0]    tag_valid,
    output logic [NTAG-1:0]    way_hit
);

    for (genvar i = 0; i < NTAG; i++) begin : g_way
        assign way_hit[i] = tag_valid[i] && (tag_addr[i*AW +: AW] == addr);
    end

endmodule

// File: rtl/bhc_snoop.sv
module bhc_snoop #(
    parameter int DW   = 8,
    parameter int NTAG = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample,
    input  logic [NTAG-1:0] way_hit,
    input  logic            mode_upd,
    input  logic [DW-1:0]   wdata,
    output logic [NTAG-1:0] snoop_way,
    output logic            snoop_inv,
    output logic            snoop_upd,
    output logic [DW-1:0]   snoop_data
);

    typedef struct packed {
        logic [NTAG-1:0] way;
        logic            inv;
        logic            upd;
        logic [DW-1:0]   data;
    } snoop_regs_t;

    snoop_regs_t regs_d, regs_q;
    logic        any_hit;

    assign any_hit = |way_hit;

    always_comb begin
        regs_d      = regs_q;
        regs_d.way  = sample ? way_hit : '0;
        regs_d.inv  = sample && any_hit && !mode_upd;
        regs_d.upd  = sample && any_hit && mode_upd;
        if (sample) begin
            regs_d.data = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign snoop_way  = regs_q.way;
    assign snoop_inv  = regs_q.inv;
    assign snoop_upd  = regs_q.upd;
    assign snoop_data = regs_q.data;

endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int NTAG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_req,
    input  logic               cycle_end,
    input  logic               dma_wr,
    input  logic [AW-1:0]      dma_addr,
    input  logic [DW-1:0]      dma_wdata,
    input  logic               snoop_mode,
    input  logic [NTAG*AW-1:0] tag_addr,
    input  logic [NTAG-1:0]    tag_valid,
    output logic               bus_oe,
    output logic               hold_ack,
    output logic               core_stall,
    output logic [NTAG-1:0]    snoop_way,
    output logic               snoop_inv,
    output logic               snoop_upd,
    output logic [DW-1:0]      snoop_data
);

    logic [NTAG-1:0] way_hit;
    logic            snoop_sample;

    bhc_hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (hold_req),
        .cycle_end  (cycle_end),
        .bus_oe     (bus_oe),
        .hold_ack   (hold_ack),
        .core_stall (core_stall)
    );

    bhc_tag_match #(.AW(AW), .NTAG(NTAG)) u_match (
        .addr      (dma_addr),
        .tag_addr  (tag_addr),
        .tag_valid (tag_valid),
        .way_hit   (way_hit)
    );

    assign snoop_sample = dma_wr && hold_ack;

    bhc_snoop #(.DW(DW), .NTAG(NTAG)) u_snoop (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (snoop_sample),
        .way_hit    (way_hit),
        .mode_upd   (snoop_mode),
        .wdata      (dma_wdata),
        .snoop_way  (snoop_way),
        .snoop_inv  (snoop_inv),
        .snoop_upd  (snoop_upd),
        .snoop_data (snoop_data)
    );

endmodule

// File: rtl/bhc_checker.sv
module bhc_checker (
    input logic clk,
    input logic rst_n,
    input logic hold_req,
    input logic cycle_end,
    input logic dma_wr,
    input logic bus_oe,
    input logic hold_ack,
    input logic core_stall,
    input logic snoop_inv,
    input logic snoop_upd
);

    a_r1_float_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> $past(hold_req && cycle_end));

    a_r2_float_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> !bus_oe);

    a_r3_ack_after_float: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(!bus_oe));

    a_r4_ack_drops_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> $past(!hold_ack));

    a_r4_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> !bus_oe);

    a_r6_stall_matches_float: assert property (@(posedge clk) disable iff (!rst_n)
        core_stall == !bus_oe);

    a_r7_snoop_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_inv || snoop_upd) |-> $past(dma_wr && hold_ack));

    a_r9_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        !(snoop_inv && snoop_upd));

endmodule

bind bus_hold_ctrl bhc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req   (hold_req),
    .cycle_end  (cycle_end),
    .dma_wr     (dma_wr),
    .bus_oe     (bus_oe),
    .hold_ack   (hold_ack),
    .core_stall (core_stall),
    .snoop_inv  (snoop_inv),
    .snoop_upd  (snoop_upd)
);

// File: tb/tb_bus_hold_ctrl.sv
`timescale 1ns/1ps
module tb_bus_hold_ctrl;

    localparam int AW   = 16;
    localparam int DW   = 8;
    localparam int NTAG = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               hold_req = 1'b0;
    logic               cycle_end = 1'b0;
    logic               dma_wr = 1'b0;
    logic [AW-1:0]      dma_addr = '0;
    logic [DW-1:0]      dma_wdata = '0;
    logic               snoop_mode = 1'b0;
    logic [NTAG*AW-1:0] tag_addr;
    logic [NTAG-1:0]    tag_valid;
    logic               bus_oe, hold_ack, core_stall, snoop_inv, snoop_upd;
    logic [NTAG-1:0]    snoop_way;
    logic [DW-1:0]      snoop_data;

    int  n_run = 0;
    int  n_fail = 0;
    int  n_cycles = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    bus_hold_ctrl #(.AW(AW), .DW(DW), .NTAG(NTAG)) dut (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .cycle_end(cycle_end),
        .dma_wr(dma_wr), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .snoop_mode(snoop_mode), .tag_addr(tag_addr), .tag_valid(tag_valid),
        .bus_oe(bus_oe), .hold_ack(hold_ack), .core_stall(core_stall),
        .snoop_way(snoop_way), .snoop_inv(snoop_inv), .snoop_upd(snoop_upd),
        .snoop_data(snoop_data)
    );

    // behavioural reference: phase 0 normal, 1 waiting, 2 floated, 3 handing back
    int           m_phase = 0;
    bit           m_ack = 0;
    bit [NTAG-1:0] m_way = '0;
    bit           m_inv = 0, m_upd = 0;
    bit [DW-1:0]  m_data = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_ack = 0; m_way = '0; m_inv = 0; m_upd = 0; m_data = '0;
        end else begin
            int nxt;
            bit [NTAG-1:0] w;
            nxt = m_phase;
            if (m_phase == 0 && hold_req) nxt = cycle_end ? 2 : 1;
            else if (m_phase == 1 && !hold_req) nxt = 0;
            else if (m_phase == 1 && cycle_end) nxt = 2;
            else if (m_phase == 2 && !hold_req) nxt = 3;
            else if (m_phase == 3) nxt = 0;
            w = '0;
            if (dma_wr && m_ack) begin
                for (int i = 0; i < NTAG; i++)
                    if (tag_valid[i] && tag_addr[i*AW +: AW] == dma_addr) w[i] = 1'b1;
                m_data = dma_wdata;
            end
            m_way = w;
            m_inv = (w != 0) && !snoop_mode;
            m_upd = (w != 0) && snoop_mode;
            m_ack = (m_phase == 2) && (nxt == 2);
            m_phase = nxt;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        bit m_oe;
        m_oe = (m_phase == 0 || m_phase == 1);
        if (!rst_n) begin
            chk("R10 reset bus_oe", 16'(bus_oe), 16'd1);
            chk("R10 reset hold_ack", 16'(hold_ack), 16'd0);
            chk("R10 reset snoop", 16'({snoop_way, snoop_inv, snoop_upd, snoop_data}), 16'd0);
        end else begin
            chk("R1 R2 R5 bus_oe", 16'(bus_oe), 16'(m_oe));
            chk("R3 R4 R5 hold_ack", 16'(hold_ack), 16'(m_ack));
            chk("R6 core_stall", 16'(core_stall), 16'(!m_oe));
            chk("R7 R8 snoop_way", 16'(snoop_way), 16'(m_way));
            chk("R7 R9 snoop_inv", 16'(snoop_inv), 16'(m_inv));
            chk("R7 R9 snoop_upd", 16'(snoop_upd), 16'(m_upd));
            if (m_upd) chk("R9 snoop_data", 16'(snoop_data), 16'(m_data));
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic dma_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic md);
        dma_wr = 1'b1; dma_addr = a; dma_wdata = d; snoop_mode = md;
        tick(1);
        dma_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog R3: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tag_addr  = {16'hBEEF, 16'h1000, 16'h2345, 16'h1000};
        tag_valid = 4'b1101;
        tick(3);                              // R10 checks during reset
        rst_n = 1'b1;
        tick(2);

        // R7: write outside a hold is ignored
        dma_write(16'h1000, 8'h11, 1'b0);
        tick(2);

        // R1: immediate boundary
        hold_req = 1'b1; cycle_end = 1'b1;
        tick(1);
        cycle_end = 1'b0;
        // R7: write in first floated cycle, acknowledge still low
        dma_write(16'h1000, 8'h22, 1'b0);
        tick(1);
        // R8 R9: double-way match, invalidate
        dma_write(16'h1000, 8'h33, 1'b0);
        // R8: invalid tag address misses
        dma_write(16'h2345, 8'h44, 1'b1);
        // R9: update mode with data
        dma_write(16'hBEEF, 8'h5A, 1'b1);
        dma_write(16'h0001, 8'h66, 1'b1);
        dma_write(16'h1000, 8'hA5, 1'b1);
        tick(3);

        // R4: release
        hold_req = 1'b0;
        dma_write(16'h1000, 8'h77, 1'b0);     // sampled at release edge, ack still 1
        tick(4);

        // R1: wait for cycle end over several lengths
        for (int len = 1; len <= 4; len++) begin
            hold_req = 1'b1; cycle_end = 1'b0;
            tick(len);
            cycle_end = 1'b1;
            tick(1);
            cycle_end = 1'b0;
            tick(3);
            hold_req = 1'b0;
            tick(3);
        end

        // R5: abandoned requests
        hold_req = 1'b1; tick(2);
        hold_req = 1'b0; cycle_end = 1'b1; tick(3);
        cycle_end = 1'b0;
        hold_req = 1'b1; tick(1);
        hold_req = 1'b0; tick(2);

        // R3 R4: one-cycle hold, and re-request during release
        hold_req = 1'b1; cycle_end = 1'b1; tick(1);
        hold_req = 1'b0; cycle_end = 1'b0; tick(1);
        hold_req = 1'b1; cycle_end = 1'b1; tick(1);
        cycle_end = 1'b0; tick(3);
        hold_req = 1'b0; tick(1);
        hold_req = 1'b1; cycle_end = 1'b1; tick(2);
        cycle_end = 1'b0;
        dma_write(16'hBEEF, 8'hC3, 1'b0);
        hold_req = 1'b0; tick(4);

        // mixed cycle_end pattern
        for (int k = 0; k < 60; k++) begin
            hold_req  = (k % 11) < 7;
            cycle_end = (k % 3) == 0;
            dma_wr    = (k % 2) == 1;
            dma_addr  = (k % 4 == 1) ? 16'h1000 : 16'hBEEF;
            dma_wdata = 8'(k * 7);
            snoop_mode = (k % 5) > 2;
            tick(1);
        end
        hold_req = 1'b0; dma_wr = 1'b0; cycle_end = 1'b0;
        tick(4);

        // R10: reset mid-hold
        hold_req = 1'b1; cycle_end = 1'b1; tick(3);
        rst_n = 1'b0; tick(2);
        hold_req = 1'b0; cycle_end = 1'b0; rst_n = 1'b1; tick(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule